// File: doc/BRIEF.md
# DSP Address Generation Unit

This block generates data-memory addresses for a signal-processing core. It keeps eight 16-bit pointer registers. Each pointer has a matching offset register and a matching modifier register. On each clock the core may present one request, which names a pointer and an addressing mode. The unit returns the effective address one cycle later. If the mode updates the pointer, the unit writes the new value back in the same cycle.

The modifier register selects the arithmetic used for both the update and the indexed address:
- All ones gives ordinary 16-bit wraparound.
- Zero gives reverse-carry arithmetic, which produces bit-reversed sequences for FFT data shuffling.
- Any other value m gives a circular buffer of m+1 entries.

All three register banks are loaded through a single write port. A request always reads the register values held before that cycle's write. There is no state machine. The only sequential elements are the three register banks and the output stage, which holds the address and the valid flag.

Top module: `dsp_agu`

## Requirements
- R1: After reset all pointer and offset registers read 0 and all modifier registers read 0xFFFF. `ea_valid` is low.
- R2: `ea_valid` is high in exactly the cycle after a cycle with `req_valid` high. `ea` carries the address for that request.
- R3: Mode 0 (indirect) and mode 7 (reserved) return the pointer as the address and leave the pointer unchanged.
- R4: Mode 1 (indexed) returns pointer plus offset, computed with the pointer's modifier arithmetic, and leaves the pointer unchanged.
- R5: Mode 2 (post-increment) and mode 3 (post-decrement) return the old pointer and then step the pointer by +1 or −1.
- R6: Mode 4 (post-add) and mode 5 (post-subtract) return the old pointer and then step the pointer by plus or minus its offset.
- R7: Mode 6 (pre-decrement) steps the pointer by −1 and returns the stepped value as the address.
- R8: A modifier of 0xFFFF gives plain 16-bit wraparound arithmetic.
- R9: Modulo arithmetic applies for a modifier m from 1 to 0xFFFE. The buffer length is m+1. The buffer base is the pointer with every bit at or below the highest set bit of m cleared. A step that passes either end of [base, base+m] wraps inside it. Steps must not exceed m+1.
- R10: A modifier of 0 gives reverse-carry arithmetic. The add or subtract carries from bit 15 toward bit 0.
- R11: The write port stores `wr_data` into the register at `wr_sel` of the bank selected by `wr_bank`: 0 pointer, 1 offset, 2 modifier. Bank code 3 changes nothing. A write is visible from the next cycle.
- R12: A write and a pointer update to the same pointer in the same cycle leave the written value.
- R13: A request uses the offset and modifier values held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request present |
| req_sel | input | 3 | Pointer index of the request |
| req_mode | input | 3 | Addressing mode code (0 to 7) |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank select: 0 pointer, 1 offset, 2 modifier, 3 none |
| wr_sel | input | 3 | Register index of the write |
| wr_data | input | 16 | Write value |
| ea | output | 16 | Effective address, registered |
| ea_valid | output | 1 | `ea` holds a request result |

## Verification
The bench targets the following corner cases, each paired with the fault it exposes:
- Circular buffers of non-power-of-two length that wrap in both directions. A design that masks to the power-of-two span instead of the true length would run past base+m.
- Pre-decrement from the buffer base. A design that returns the old pointer, or wraps to the span edge, would give the wrong address.
- A reverse-carry walk with an offset of half the transform size, which must produce the bit-reversed index order. A forward carry would give a linear count.
- A same-cycle write and update to one pointer, where a design favouring the update would lose the written value.
- Bank code 3, which would otherwise corrupt a register.
- Same-cycle writes of the offset during an indexed request, which would expose a bypass path.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AM_IND    = 3'd0,
        AM_IDX    = 3'd1,
        AM_PINC   = 3'd2,
        AM_PDEC   = 3'd3,
        AM_PADD   = 3'd4,
        AM_PSUB   = 3'd5,
        AM_PREDEC = 3'd6,
        AM_RSVD   = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        BANK_PTR  = 2'd0,
        BANK_OFF  = 2'd1,
        BANK_MOD  = 2'd2,
        BANK_NONE = 2'd3
    } agu_bank_e;

    typedef enum logic [1:0] {
        ARITH_LIN,
        ARITH_MOD,
        ARITH_REV
    } agu_arith_e;

endpackage

// File: rtl/agu_bank.sv
module agu_bank #(
    parameter int          N       = 8,
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0,
    localparam int         IW      = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    input  logic                upd_en,
    input  logic [IW-1:0]       upd_idx,
    input  logic [W-1:0]        upd_data,
    output logic [N-1:0][W-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= RST_VAL;
            end else if (wr_en && wr_idx == IW'(i)) begin
                q[i] <= wr_data;
            end else if (upd_en && upd_idx == IW'(i)) begin
                q[i] <= upd_data;
            end
        end

        // An explicit write always lands, even with a concurrent update
        assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IW'(i)) |=> (q[i] == $past(wr_data)));
    end

endmodule

// File: rtl/agu_decode.sv
module agu_decode
    import agu_pkg::*;
(
    input  agu_mode_e mode,
    output logic      use_off,
    output logic      sub,
    output logic      pre_upd,
    output logic      addr_idx,
    output logic      wb
);

    always_comb begin
        use_off  = 1'b0;
        sub      = 1'b0;
        pre_upd  = 1'b0;
        addr_idx = 1'b0;
        wb       = 1'b0;
        unique case (mode)
            AM_IND:    ;
            AM_IDX:    addr_idx = 1'b1;
            AM_PINC:   wb = 1'b1;
            AM_PDEC:   begin wb = 1'b1; sub = 1'b1; end
            AM_PADD:   begin wb = 1'b1; use_off = 1'b1; end
            AM_PSUB:   begin wb = 1'b1; use_off = 1'b1; sub = 1'b1; end
            AM_PREDEC: begin wb = 1'b1; sub = 1'b1; pre_upd = 1'b1; end
            AM_RSVD:   ;
        endcase
    end

endmodule

// File: rtl/agu_arith.sv
module agu_arith
    import agu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] step,
    input  logic [W-1:0] modv,
    input  logic [W-1:0] span,
    input  logic         sub,
    output logic [W-1:0] res
);

    agu_arith_e kind;
    logic [W-1:0] rp, rs, rsum;
    logic [W:0]   off, len, t;

    always_comb begin
        if (&modv)             kind = ARITH_LIN;
        else if (modv == '0)   kind = ARITH_REV;
        else                   kind = ARITH_MOD;

        for (int b = 0; b < W; b++) begin
            rp[b] = ptr[W-1-b];
            rs[b] = step[W-1-b];
        end
        rsum = sub ? (rp - rs) : (rp + rs);

        off = {1'b0, ptr & span};
        len = {1'b0, modv} + 1'b1;
        t   = '0;
        res = ptr;

        unique case (kind)
            ARITH_LIN: res = sub ? (ptr - step) : (ptr + step);
            ARITH_REV: begin
                for (int b = 0; b < W; b++) res[b] = rsum[W-1-b];
            end
            ARITH_MOD: begin
                if (!sub) begin
                    t = off + {1'b0, step};
                    if (t > {1'b0, modv}) t = t - len;
                end else begin
                    t = off - {1'b0, step};
                    if (t[W]) t = t + len;
                end
                res = (ptr & ~span) | t[W-1:0];
            end
            default: res = ptr;
        endcase
    end

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
    import agu_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 16,
    localparam int IW   = $clog2(NREG),
    localparam int LOGW = $clog2(AW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [IW-1:0] req_sel,
    input  logic [2:0]    req_mode,
    input  logic          wr_en,
    input  logic [1:0]    wr_bank,
    input  logic [IW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] ea,
    output logic          ea_valid
);

    logic [NREG-1:0][AW-1:0] ptr_q, off_q, mod_q;
    logic [AW-1:0] cur_r, cur_n, cur_m, span;
    logic [AW-1:0] upd_res, idx_res, step, addr;
    logic use_off, sub, pre_upd, addr_idx, wb;
    logic upd_en, wr_hit;

    assign cur_r = ptr_q[req_sel];
    assign cur_n = off_q[req_sel];
    assign cur_m = mod_q[req_sel];

    // Fill every bit below the top set bit of the modifier
    always_comb begin
        span = cur_m;
        for (int i = 0; i < LOGW; i++) span = span | (span >> (1 << i));
    end

    agu_decode u_dec (
        .mode    (agu_mode_e'(req_mode)),
        .use_off (use_off),
        .sub     (sub),
        .pre_upd (pre_upd),
        .addr_idx(addr_idx),
        .wb      (wb)
    );

    assign step = use_off ? cur_n : AW'(1);

    agu_arith #(.W(AW)) u_upd (
        .ptr(cur_r), .step(step), .modv(cur_m), .span(span), .sub(sub), .res(upd_res)
    );

    agu_arith #(.W(AW)) u_idx (
        .ptr(cur_r), .step(cur_n), .modv(cur_m), .span(span), .sub(1'b0), .res(idx_res)
    );

    always_comb begin
        if (pre_upd)       addr = upd_res;
        else if (addr_idx) addr = idx_res;
        else               addr = cur_r;
    end

    assign upd_en = req_valid && wb;
    assign wr_hit = wr_en && (wr_bank == BANK_PTR) && (wr_sel == req_sel);

    agu_bank #(.N(NREG), .W(AW), .RST_VAL('0)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_bank == BANK_PTR), .wr_idx(wr_sel), .wr_data(wr_data),
        .upd_en(upd_en), .upd_idx(req_sel), .upd_data(upd_res),
        .q(ptr_q)
    );

    agu_bank #(.N(NREG), .W(AW), .RST_VAL('0)) u_off (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_bank == BANK_OFF), .wr_idx(wr_sel), .wr_data(wr_data),
        .upd_en(1'b0), .upd_idx('0), .upd_data('0),
        .q(off_q)
    );

    agu_bank #(.N(NREG), .W(AW), .RST_VAL('1)) u_mod (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_bank == BANK_MOD), .wr_idx(wr_sel), .wr_data(wr_data),
        .upd_en(1'b0), .upd_idx('0), .upd_data('0),
        .q(mod_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea       <= req_valid ? addr : ea;
            ea_valid <= req_valid;
        end
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ea_valid);
    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ea_valid);

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 3'd0 || req_mode == 3'd1 || req_mode == 3'd7) && !wr_hit)
        |=> (ptr_q[$past(req_sel)] == $past(cur_r)));

    assert_linear_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd2 && (&cur_m) && !wr_hit)
        |=> (ptr_q[$past(req_sel)] == $past(cur_r) + AW'(1)));

    assert_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wb && !wr_hit && !(&cur_m) && (cur_m != '0)
         && ((cur_r & span) <= cur_m) && ({1'b0, cur_n} <= {1'b0, cur_m} + 1'b1))
        |=> (((ptr_q[$past(req_sel)] & ~$past(span)) == ($past(cur_r) & ~$past(span)))
             && ((ptr_q[$past(req_sel)] & $past(span)) <= $past(cur_m))));

endmodule

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [2:0]  req_mode = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_bank = '0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] ea;
    logic        ea_valid;

    always #2.5 clk = ~clk;

    dsp_agu dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel),
        .wr_data(wr_data), .ea(ea), .ea_valid(ea_valid)
    );

    int checks = 0;
    int errors = 0;
    int mr[8], mn[8], mm[8];
    bit    exp_v = 1'b0;
    int    exp_ea = 0;
    string exp_tag = "R1";

    function automatic int rev16(input int x);
        int y = 0;
        for (int b = 0; b < 16; b++) if (x[b]) y |= (1 << (15 - b));
        return y;
    endfunction

    function automatic int blksize(input int m);
        int s = 1;
        while (s < m + 1) s = s * 2;
        return s;
    endfunction

    function automatic int madv(input int r, input int s, input bit neg, input int m);
        int len, size, base, t;
        if (m == 65535) return (neg ? r - s : r + s) & 65535;
        if (m == 0) begin
            t = neg ? rev16(r) - rev16(s) : rev16(r) + rev16(s);
            return rev16(t & 65535);
        end
        len  = m + 1;
        size = blksize(m);
        base = r - (r % size);
        t    = neg ? (r % size) - s : (r % size) + s;
        t    = ((t % len) + len) % len;
        return base + t;
    endfunction

    task automatic compare();
        checks++;
        if (exp_v) begin
            if (!ea_valid || ea != exp_ea[15:0]) begin
                errors++;
                $display("FAIL %s: ea_valid=%0d ea=%h expected valid=1 ea=%h",
                         exp_tag, ea_valid, ea, exp_ea[15:0]);
            end
        end else if (ea_valid) begin
            errors++;
            $display("FAIL R2: ea_valid=1 expected 0 (%s)", exp_tag);
        end
    endtask

    task automatic tick(input bit v, input int sel, input int mode, input bit we,
                        input int bank, input int wsel, input int wdata, input string tag);
        int r, n, m, nr, a;
        @(negedge clk);
        compare();
        req_valid = v; req_sel = sel[2:0]; req_mode = mode[2:0];
        wr_en = we; wr_bank = bank[1:0]; wr_sel = wsel[2:0]; wr_data = wdata[15:0];
        exp_v = v;
        exp_tag = (tag == "") ? "R2" : tag;
        if (v) begin
            r = mr[sel]; n = mn[sel]; m = mm[sel]; nr = r; a = r;
            case (mode)
                1: a = madv(r, n, 1'b0, m);
                2: nr = madv(r, 1, 1'b0, m);
                3: nr = madv(r, 1, 1'b1, m);
                4: nr = madv(r, n, 1'b0, m);
                5: nr = madv(r, n, 1'b1, m);
                6: begin nr = madv(r, 1, 1'b1, m); a = nr; end
                default: ;
            endcase
            mr[sel] = nr;
            exp_ea = a;
            if (tag == "") begin
                case (mode)
                    1:       exp_tag = "R4";
                    2, 3:    exp_tag = "R5";
                    4, 5:    exp_tag = "R6";
                    6:       exp_tag = "R7";
                    default: exp_tag = "R3";
                endcase
                if (m == 65535)  exp_tag = {exp_tag, "/R8"};
                else if (m == 0) exp_tag = {exp_tag, "/R10"};
                else             exp_tag = {exp_tag, "/R9"};
            end
        end
        if (we) begin
            case (bank)
                0: mr[wsel] = wdata & 65535;
                1: mn[wsel] = wdata & 65535;
                2: mm[wsel] = wdata & 65535;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int bank, input int sel, input int d, input string tag);
        tick(1'b0, 0, 0, 1'b1, bank, sel, d, tag);
    endtask

    task automatic rq(input int sel, input int mode, input string tag);
        tick(1'b1, sel, mode, 1'b0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cm[8], cn[8], cr[8];
        cm = '{65535, 65535, 4, 7, 19, 0, 0, 255};
        cn = '{3, 256, 3, 5, 20, 8, 256, 17};
        cr = '{0, 16, 64, 4656, 8192, 0, 0, 1280};
        for (int i = 0; i < 8; i++) begin mr[i] = 0; mn[i] = 0; mm[i] = 65535; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values seen through the request path
        rq(3, 0, "R1");
        rq(3, 1, "R1");
        rq(3, 3, "R1");
        rq(3, 0, "R1");
        tick(1'b0, 0, 0, 1'b0, 0, 0, 0, "R2");

        for (int i = 0; i < 8; i++) begin
            wr(2, i, cm[i], "R11");
            wr(1, i, cn[i], "R11");
            wr(0, i, cr[i], "R11");
        end
        for (int i = 0; i < 8; i++) rq(i, 0, "R11");

        // R8: linear wrap at the top
        wr(0, 0, 65535, "R8");
        rq(0, 2, "R8");
        rq(0, 0, "R8");
        rq(0, 6, "R8");

        // R9: length-5 buffer at 0x40, both ends
        wr(0, 2, 68, "R9");
        rq(2, 2, "R9");
        rq(2, 0, "R9");
        rq(2, 6, "R9");
        rq(2, 4, "R9");
        rq(2, 5, "R9");
        rq(2, 5, "R9");
        rq(2, 1, "R9");
        // length-20 buffer, offset equal to its length
        for (int k = 0; k < 6; k++) rq(4, (k % 2) ? 5 : 4, "R9");

        // R10: bit-reversed walk over 16 points
        for (int k = 0; k < 18; k++) rq(5, 4, "R10");
        for (int k = 0; k < 6; k++) rq(6, 3, "R10");

        // R11: bank code 3 touches nothing
        wr(3, 2, 1234, "R11");
        wr(3, 1, 0, "R11");
        rq(2, 0, "R11");
        rq(1, 1, "R11");
        rq(1, 3, "R11");

        // R12: same-cycle write and update
        tick(1'b1, 1, 2, 1'b1, 0, 1, 4660, "R12");
        rq(1, 0, "R12");
        tick(1'b1, 3, 6, 1'b1, 0, 3, 4661, "R12");
        rq(3, 0, "R12");

        // R13: same-cycle offset and modifier writes do not bypass
        tick(1'b1, 1, 1, 1'b1, 1, 1, 61, "R13");
        rq(1, 1, "R13");
        tick(1'b1, 7, 4, 1'b1, 2, 7, 65535, "R13");
        rq(7, 4, "R13");
        wr(2, 7, 255, "R13");
        wr(0, 7, 1280, "R13");

        for (int k = 0; k < 3000; k++) begin
            int sel, mode, bank, wsel, d, m;
            bit we;
            sel  = $urandom % 8;
            mode = $urandom % 8;
            we   = ($urandom % 4) == 0;
            bank = $urandom % 4;
            if (bank == 2) bank = 3;
            wsel = $urandom % 8;
            m    = mm[wsel];
            d    = $urandom % 65536;
            if (m != 0 && m != 65535) begin
                if (bank == 0) d = (mr[wsel] - (mr[wsel] % blksize(m))) + ($urandom % (m + 1));
                if (bank == 1) d = $urandom % (m + 2);
            end
            tick(($urandom % 8) != 0, sel, mode, we, bank, wsel, d, "");
        end
        tick(1'b0, 0, 0, 1'b0, 0, 0, 0, "R2");
        tick(1'b0, 0, 0, 1'b0, 0, 0, 0, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule